// File: doc/BRIEF.md
# Center-Aligned Up/Down Timer Counter

This block is a timer counter that counts in a symmetric triangle, up and then down. A prescaler divides the clock by a programmable ratio. Each prescaler terminal count moves the counter one step. The counter climbs from zero to the active reload value, which raises an overflow. It then descends back to zero, which raises an underflow. One full triangle takes twice the reload value in counter steps. A direction output shows which way the counter is moving, and software cannot set it.

The reload value is written into a preload input. It is copied into an active shadow register only when an update event fires. Software can therefore change the period without glitching the triangle that is running. An update event fires at each turnaround, or on a software strobe. The update-disable control blocks update events. The update-source control stops software strobes from raising the sticky update flag. Each compare channel watches the counter. It latches a sticky flag when the counter steps onto the channel's compare value, in the directions that the mode code allows.

All pins are plain control and status signals. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `updn_timer`

## Requirements
- R1: With active reload A > 0, an up step from A-1 (or higher) loads A, flags an overflow and turns the counter downward. A down step from 1 loads 0, flags an underflow and turns it upward. All other steps move the counter by one. A triangle is 2A steps.
- R2: The counter takes one step every PSC+1 clock cycles while `cnt_en` is 1 and `mode` is not 00.
- R3: When `cnt_en` is 0 or `mode` is 00, the counter, the direction and the prescaler hold, and no turnaround occurs.
- R4: `dir_down` is 1 exactly while counting down. It rises at an overflow and falls at an underflow, at a forced update, or when the active reload is 0.
- R5: When `upd_dis` is 0, each overflow and each underflow produces a one-cycle `upd_pulse`. The pulse appears in the same cycle as the new counter value, one register stage after the stepping clock.
- R6: The active reload copies `arr_pre` only on an update event. While `upd_dis` is 1, no update event occurs and counting continues with the old reload.
- R7: When `force_upd` is 1, the counter and the prescaler return to 0 and the direction returns to up. It also gives an update event unless `upd_dis` is 1.
- R8: `uif` is sticky. An update event sets it, and `uif_clr` clears it. A set wins over a clear in the same cycle.
- R9: When `upd_src_sel` is 1, a forced update still pulses `upd_pulse` but does not set `uif`.
- R10: `mode` 01 sets a channel flag only on down steps, 10 only on up steps, and 11 on both. A flag is set when a step lands on the channel's compare value. Channel k's compare value is bits [k*CNT_W +: CNT_W] of `cmp_vals`. Flags are sticky until `cmp_clr[k]`, and a set wins over a clear.
- R11: With active reload 0, the counter stays at 0 and no overflow or underflow occurs.
- R12: After reset, the counter, the direction, the prescaler, the active reload, `uif`, `upd_pulse` and all compare flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| mode | input | 2 | Mode code: 00 stopped, 01 down-match, 10 up-match, 11 both |
| psc | input | PSC_W | Prescaler ratio minus one |
| arr_pre | input | CNT_W | Reload preload value |
| cmp_vals | input | NUM_CH*CNT_W | Packed compare values, one per channel |
| upd_dis | input | 1 | Blocks update events |
| upd_src_sel | input | 1 | Forced updates do not set `uif` |
| force_upd | input | 1 | Software update strobe |
| uif_clr | input | 1 | Clears `uif` |
| cmp_clr | input | NUM_CH | Per-channel compare flag clear |
| cnt_out | output | CNT_W | Counter value |
| dir_down | output | 1 | 1 while counting down |
| upd_pulse | output | 1 | One-cycle update event pulse |
| uif | output | 1 | Sticky update interrupt flag |
| cmp_flag | output | NUM_CH | Sticky compare flags |

## Verification
Every output is a single register stage away from the inputs that drive it. The counter, direction, update pulse, update flag and compare flags all change at the rising edge that samples a prescaler terminal count or a strobe. The bench drives its inputs on the falling edge. It compares every output at the next falling edge against a cycle model that advances on the same rising edge from the same sampled inputs. Directed checks of the period, the reload hold and the reload-zero case count falling-edge samples across a known number of clock cycles.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    CM_OFF  = 2'b00,
    CM_DOWN = 2'b01,
    CM_UP   = 2'b10,
    CM_BOTH = 2'b11
  } cmode_e;

  // true when a step in the given direction may set a compare flag
  function automatic logic step_allowed(input cmode_e m, input logic going_down);
    case (m)
      CM_DOWN: step_allowed = going_down;
      CM_UP:   step_allowed = !going_down;
      CM_BOTH: step_allowed = 1'b1;
      default: step_allowed = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/updn_prescaler.sv
module updn_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PSC_W-1:0] ratio,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;

  assign tick = run && (div_q == ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clear)  div_q <= '0;
    else if (run)    div_q <= tick ? '0 : div_q + PSC_W'(1);
  end
endmodule

// File: rtl/updn_core.sv
module updn_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             upd_dis,
  input  logic [CNT_W-1:0] arr_pre,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_q,
  output logic             step,
  output logic             step_dn,
  output logic [CNT_W-1:0] cnt_n,
  output logic             uev
);
  logic [CNT_W-1:0] arr_q;
  logic             dir_n, turn_up, turn_dn;

  always_comb begin
    cnt_n   = cnt_q;
    dir_n   = dir_q;
    step    = 1'b0;
    step_dn = 1'b0;
    turn_up = 1'b0;
    turn_dn = 1'b0;
    if (force_upd) begin
      cnt_n = '0;
      dir_n = 1'b0;
    end else if (tick) begin
      if (arr_q == '0) begin
        cnt_n = '0;
        dir_n = 1'b0;
      end else if (!dir_q) begin
        step = 1'b1;
        if (cnt_q >= arr_q - CNT_W'(1)) begin
          cnt_n   = arr_q;
          dir_n   = 1'b1;
          turn_up = 1'b1;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end else begin
        step    = 1'b1;
        step_dn = 1'b1;
        if (cnt_q <= CNT_W'(1)) begin
          cnt_n   = '0;
          dir_n   = 1'b0;
          turn_dn = 1'b1;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign uev = !upd_dis && (force_upd || turn_up || turn_dn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      arr_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
      if (uev) arr_q <= arr_pre;
    end
  end
endmodule

// File: rtl/updn_uflag.sv
module updn_uflag (
  input  logic clk,
  input  logic rst_n,
  input  logic uev,
  input  logic force_upd,
  input  logic src_sel,
  input  logic clr,
  output logic pulse_q,
  output logic flag_q
);
  logic set_flag;
  assign set_flag = uev && !(force_upd && src_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= uev;
      if (set_flag) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/updn_cmp_ch.sv
module updn_cmp_ch
  import updn_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             step_dn,
  input  logic [CNT_W-1:0] next_val,
  input  logic [CNT_W-1:0] match_val,
  input  cmode_e           mode,
  input  logic             clr,
  output logic             flag_q
);
  logic hit;
  assign hit = step && (next_val == match_val) && step_allowed(mode, step_dn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cnt_en,
  input  logic [1:0]              mode,
  input  logic [PSC_W-1:0]        psc,
  input  logic [CNT_W-1:0]        arr_pre,
  input  logic [NUM_CH*CNT_W-1:0] cmp_vals,
  input  logic                    upd_dis,
  input  logic                    upd_src_sel,
  input  logic                    force_upd,
  input  logic                    uif_clr,
  input  logic [NUM_CH-1:0]       cmp_clr,
  output logic [CNT_W-1:0]        cnt_out,
  output logic                    dir_down,
  output logic                    upd_pulse,
  output logic                    uif,
  output logic [NUM_CH-1:0]       cmp_flag
);
  cmode_e           mode_e;
  logic             running, tick, step, step_dn, uev;
  logic [CNT_W-1:0] cnt_n;

  assign mode_e  = cmode_e'(mode);
  assign running = cnt_en && (mode_e != CM_OFF);

  updn_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(running), .clear(force_upd),
    .ratio(psc), .tick(tick)
  );

  updn_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .force_upd(force_upd),
    .upd_dis(upd_dis), .arr_pre(arr_pre), .cnt_q(cnt_out), .dir_q(dir_down),
    .step(step), .step_dn(step_dn), .cnt_n(cnt_n), .uev(uev)
  );

  updn_uflag u_flag (
    .clk(clk), .rst_n(rst_n), .uev(uev), .force_upd(force_upd),
    .src_sel(upd_src_sel), .clr(uif_clr), .pulse_q(upd_pulse), .flag_q(uif)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    updn_cmp_ch #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .step(step), .step_dn(step_dn),
      .next_val(cnt_n), .match_val(cmp_vals[k*CNT_W +: CNT_W]),
      .mode(mode_e), .clr(cmp_clr[k]), .flag_q(cmp_flag[k])
    );
  end
endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [1:0]       mode,
  input logic             force_upd,
  input logic [CNT_W-1:0] cnt_out,
  input logic             dir_down,
  input logic             upd_pulse,
  input logic             uif
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cnt_en || mode == 2'b00) && !force_upd) |=> ($stable(cnt_out) && $stable(dir_down)));

  assert_dir_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_down) |-> (cnt_out != '0));

  assert_dir_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_down) |-> (cnt_out == '0));

  assert_pulse_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> (cnt_out == '0 || dir_down));

  assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (cnt_out == '0 && !dir_down));

  assert_uif_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uif) |-> upd_pulse);
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .force_upd(force_upd),
  .cnt_out(cnt_out), .dir_down(dir_down), .upd_pulse(upd_pulse), .uif(uif)
);

// File: tb/updn_timer_tb_top.sv
module updn_timer_tb_top;
  localparam int CW = 16;
  localparam int PW = 16;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [PW-1:0] psc = '0;
  logic [CW-1:0] arr_pre = '0;
  logic [NC*CW-1:0] cmp_vals = '0;
  logic          upd_dis = 1'b0, upd_src_sel = 1'b0, force_upd = 1'b0, uif_clr = 1'b0;
  logic [NC-1:0] cmp_clr = '0;
  logic [CW-1:0] cnt_out;
  logic          dir_down, upd_pulse, uif;
  logic [NC-1:0] cmp_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  updn_timer #(.CNT_W(CW), .PSC_W(PW), .NUM_CH(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .psc(psc),
    .arr_pre(arr_pre), .cmp_vals(cmp_vals), .upd_dis(upd_dis),
    .upd_src_sel(upd_src_sel), .force_upd(force_upd), .uif_clr(uif_clr),
    .cmp_clr(cmp_clr), .cnt_out(cnt_out), .dir_down(dir_down),
    .upd_pulse(upd_pulse), .uif(uif), .cmp_flag(cmp_flag)
  );

  // ---------------- reference model, built from the requirements -------
  logic [CW-1:0] m_cnt, m_arr;
  logic [PW-1:0] m_ps;
  logic          m_dir, m_pulse, m_uif;
  logic [NC-1:0] m_cmp;

  function automatic bit dir_ok(input logic [1:0] md, input bit dn);
    return (md == 2'b11) || (md == 2'b01 && dn) || (md == 2'b10 && !dn);
  endfunction

  always @(posedge clk) begin
    bit tk, ev, stp, sdn, turn;
    logic [CW-1:0] nx;
    if (!rst_n) begin
      m_cnt = '0; m_arr = '0; m_ps = '0; m_dir = 0; m_pulse = 0; m_uif = 0; m_cmp = '0;
    end else begin
      tk = cnt_en && mode != 2'b00 && m_ps == psc;
      stp = 0; sdn = 0; turn = 0; nx = m_cnt;
      if (force_upd) begin
        nx = '0; m_dir = 0; m_ps = '0;
      end else begin
        if (cnt_en && mode != 2'b00) m_ps = tk ? '0 : m_ps + 1'b1;
        if (tk) begin
          if (m_arr == 0) begin nx = '0; m_dir = 0; end
          else if (!m_dir) begin
            stp = 1;
            if (m_cnt + 1 >= m_arr) begin nx = m_arr; m_dir = 1; turn = 1; end
            else nx = m_cnt + 1'b1;
          end else begin
            stp = 1; sdn = 1;
            if (m_cnt <= 1) begin nx = '0; m_dir = 0; turn = 1; end
            else nx = m_cnt - 1'b1;
          end
        end
      end
      ev = !upd_dis && (force_upd || turn);
      m_pulse = ev;
      if (ev && !(force_upd && upd_src_sel)) m_uif = 1;
      else if (uif_clr) m_uif = 0;
      for (int k = 0; k < NC; k++) begin
        if (stp && nx == cmp_vals[k*CW +: CW] && dir_ok(mode, sdn)) m_cmp[k] = 1;
        else if (cmp_clr[k]) m_cmp[k] = 0;
      end
      if (ev) m_arr = arr_pre;
      m_cnt = nx;
    end
  end

  // ---------------- check helpers --------------------------------------
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check(cnt_out == m_cnt, "R1 counter", cnt_out, m_cnt);
    check(dir_down == m_dir, "R4 direction", dir_down, m_dir);
    check(upd_pulse == m_pulse, "R5 update pulse", upd_pulse, m_pulse);
    check(uif == m_uif, "R8 update flag", uif, m_uif);
    check(cmp_flag == m_cmp, "R10 compare flags", cmp_flag, m_cmp);
  endtask

  task automatic step_cyc();
    @(negedge clk);
    force_upd = 0; uif_clr = 0; cmp_clr = '0;
    compare_all();
  endtask

  task automatic pulse_force();
    @(negedge clk); force_upd = 1;
    step_cyc();
  endtask

  // ---------------- stimulus -------------------------------------------
  initial begin
    int mx, npulse, nchg;
    logic [CW-1:0] prev;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    check(cnt_out == 0 && dir_down == 0 && uif == 0 && upd_pulse == 0 && cmp_flag == 0,
          "R12 reset", {cnt_out, dir_down, uif, cmp_flag}, 0);

    // R9 then R8: forced updates with and without source select
    upd_src_sel = 1; arr_pre = 3;
    pulse_force();
    check(upd_pulse == 1, "R9 pulse on forced update", upd_pulse, 1);
    check(uif == 0, "R9 flag suppressed", uif, 0);
    upd_src_sel = 0;
    pulse_force();
    check(uif == 1, "R8 flag set by forced update", uif, 1);
    @(negedge clk); uif_clr = 1; step_cyc();
    check(uif == 0, "R8 flag cleared", uif, 0);

    // R6: reload held while updates are disabled
    mode = 2'b11; psc = 0; cnt_en = 1; upd_dis = 1; arr_pre = 5;
    mx = 0;
    repeat (30) begin step_cyc(); if (cnt_out > mx) mx = cnt_out; end
    check(mx == 3, "R6 old reload kept while disabled", mx, 3);
    upd_dis = 0; mx = 0;
    repeat (30) begin step_cyc(); if (cnt_out > mx) mx = cnt_out; end
    check(mx == 5, "R6 new reload after update", mx, 5);

    // R2: prescaler ratio 3, 30 clocks give 10 steps
    psc = 2; arr_pre = 4;
    pulse_force();
    nchg = 0; prev = cnt_out;
    repeat (30) begin step_cyc(); if (cnt_out != prev) nchg++; prev = cnt_out; end
    check(nchg == 10, "R2 step rate", nchg, 10);

    // R3: hold with enable low and with mode 00
    cnt_en = 0; prev = cnt_out;
    repeat (10) step_cyc();
    check(cnt_out == prev, "R3 hold on enable low", cnt_out, prev);
    cnt_en = 1; mode = 2'b00; prev = cnt_out;
    repeat (10) step_cyc();
    check(cnt_out == prev, "R3 hold on mode 00", cnt_out, prev);
    mode = 2'b11;

    // R11: reload zero
    psc = 0; arr_pre = 0;
    pulse_force();
    npulse = 0; mx = 0;
    repeat (20) begin step_cyc(); npulse += upd_pulse; if (cnt_out > mx) mx = cnt_out; end
    check(mx == 0 && npulse == 0, "R11 zero reload idle", mx + npulse, 0);

    // R7: forced update mid-count with update disabled still resets
    arr_pre = 6; pulse_force();
    repeat (9) step_cyc();
    upd_dis = 1; pulse_force();
    check(cnt_out == 0 && dir_down == 0 && upd_pulse == 0, "R7 forced reset, no event",
          {cnt_out, dir_down, upd_pulse}, 0);
    upd_dis = 0;

    // constrained random with model comparison (R1, R4, R5, R10 in bulk)
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (i % 250 == 0) begin
        psc = PW'($urandom_range(0, 2));
        mode = 2'($urandom_range(0, 7) == 0 ? 0 : $urandom_range(1, 3));
        upd_dis = ($urandom_range(0, 3) == 0);
        upd_src_sel = $urandom_range(0, 1);
        for (int k = 0; k < NC; k++) cmp_vals[k*CW +: CW] = CW'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 59) == 0) arr_pre = CW'($urandom_range(0, 7));
      cnt_en = ($urandom_range(0, 39) != 0);
      force_upd = ($urandom_range(0, 96) == 0);
      uif_clr = ($urandom_range(0, 22) == 0);
      cmp_clr = NC'($urandom_range(0, 28) == 0 ? $urandom_range(1, 3) : 0);
      @(negedge clk);
      compare_all();
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule